// File: doc/BRIEF.md
# Opcode-Menu Serial Flash Controller

This block is a register-driven SPI master for serial NOR flash. Software loads a table of eight command opcodes, each with a two-bit transaction type, and two prefix opcodes. It then fills in a flash address and a byte buffer, and writes a control word. The control word picks a table entry, a byte count, and whether a data phase and an atomic prefix are wanted. The controller then runs the whole transaction on the SPI pins without further help and raises a done flag at the end.

A transaction frame is the opcode, then a 24-bit address sent most significant byte first when the type asks for one, then the data bytes. Write types shift bytes out of the buffer and read types shift received bytes into it. In atomic mode a prefix opcode, typically a write-enable, goes out first in its own chip-select frame, and the main frame follows after a guaranteed idle gap. A lock input freezes the opcode table until reset, so a boot stage can fix the allowed command set.

Top module: `opmenu_spi_ctrl`

## Requirements
- R1: Word registers sit at these byte offsets: status 0x00, control 0x04, address 0x08, buffer 0x10 to 0x4F, prefixes 0x50 (prefix 0 in bits 7:0, prefix 1 in bits 15:8), types 0x54 (entry n in bits 2n+1:2n), menu 0x58 (entries 0 to 3, entry 0 in bits 7:0) and 0x5C (entries 4 to 7). Each reads back what was written, and every register reads zero after reset.
- R2: Status bit 0 is high while a cycle runs and chip select is low only then. Bit 2 (done) rises one clock after bit 0 falls, at the end of every accepted cycle. Writing 1 to bit 2 or bit 3 of the status register clears that bit.
- R3: A control write with bit 1 set while a cycle runs sets status bit 3 and leaves the running cycle unchanged.
- R4: Control bits 6:4 pick the menu entry. Its opcode is the first byte of the main frame. For types 2 and 3 (bit 1 of the type set), bits 23:16, 15:8 and 7:0 of the address register follow in that order. Bits 31:24 are never sent.
- R5: When control bit 14 is set, the data phase moves control bits 13:8 plus one bytes. For write types (type bit 0 set) these are buffer bytes 0 upward, where byte k sits in the buffer word at 0x10+4*(k/4), bits 8*(k%4)+7:8*(k%4). Up to 64 bytes may move.
- R6: For read types (type bit 0 clear), the k-th received data byte is stored at buffer byte k, in the same packing as R5.
- R7: When control bit 14 is clear, the frame has no data phase.
- R8: When control bit 2 is set, a frame that holds only the prefix goes first. It carries prefix 1 when control bit 3 is set and prefix 0 otherwise. The main frame follows.
- R9: Between the prefix frame and the main frame, chip select stays high for at least two serial clock periods.
- R10: Once the lock input has been seen high, writes to the prefix, type and menu registers have no effect until reset.
- R11: The serial clock idles low whenever chip select is high (SPI mode 0). Data is sampled on rising edges and driven on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_in | input | 1 | Table lock request, sticky once seen |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset, word aligned |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Register reads are combinational. The bench therefore samples bus_rdata one nanosecond after the falling edge on which it sets the offset. Busy is visible on the edge that accepts the start write, so a status read in the next cycle must show it. Done appears one clock after busy drops, so the bench polls the done bit rather than busy. Frame contents come from a bench flash model that logs bytes on rising serial clock edges. The model answers with a byte value that depends only on the byte position in the frame, so read-back buffer bytes can be predicted arithmetically.

// File: rtl/opmenu_spi_pkg.sv
// Shared offsets, bit positions and sequencer phases for the opcode-menu
// SPI controller. Assumes a fixed 7-bit word-aligned register window.
package opmenu_spi_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_STAT    = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_ADDR    = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_BUF     = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_PREF    = 7'h50;
    localparam logic [ADDR_W-1:0] OFS_TYPE    = 7'h54;
    localparam logic [ADDR_W-1:0] OFS_MENU_LO = 7'h58;
    localparam logic [ADDR_W-1:0] OFS_MENU_HI = 7'h5C;

    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 2;
    localparam int ST_ERR  = 3;

    localparam int CT_GO   = 1;
    localparam int CT_ATOM = 2;
    localparam int CT_PSEL = 3;
    localparam int CT_IDX  = 4;
    localparam int CT_CNT  = 8;
    localparam int CT_DEN  = 14;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_GAP,
        PH_CMD,
        PH_ADR,
        PH_DAT
    } phase_t;
endpackage

// File: rtl/opmenu_spi_regs.sv
// Register file and byte buffer. Decodes bus writes, holds the opcode table
// behind a sticky lock, and selects the table entry for a start request.
// Assumes single-cycle bus writes and combinational reads.
module opmenu_spi_regs
    import opmenu_spi_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int CNT_W = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              cyc_end,
    output logic              go,
    output logic              go_atom,
    output logic              go_den,
    output logic [CNT_W-1:0]  go_cnt,
    output logic [23:0]       go_addr,
    output logic [7:0]        sel_opcode,
    output logic [1:0]        sel_type,
    output logic [7:0]        sel_prefix,
    input  logic [CNT_W-1:0]  buf_rd_idx,
    output logic [7:0]        buf_rd_byte,
    input  logic              buf_we,
    input  logic [CNT_W-1:0]  buf_wr_idx,
    input  logic [7:0]        buf_wr_byte,
    output logic              st_done,
    output logic              st_err,
    output logic              lock_q,
    output logic [63:0]       menu_q
);
    localparam int WSEL_W = CNT_W - 2;

    logic [15:0] ctrl_q;
    logic [31:0] addr_q;
    logic [15:0] pref_q;
    logic [15:0] type_q;
    logic [7:0]  buf_q [BUF_BYTES];

    logic              lock_eff;
    logic              wr_stat, wr_ctrl, wr_addr, wr_pref, wr_type, wr_mlo, wr_mhi;
    logic              buf_hit;
    logic [ADDR_W-1:0] woff;
    logic [WSEL_W-1:0] wsel;
    logic [2:0]        idx_w;

    // Address decode for writes and buffer word selection
    always_comb begin
        woff     = bus_addr - OFS_BUF;
        wsel     = woff[CNT_W-1:2];
        buf_hit  = (bus_addr >= OFS_BUF) && (woff < ADDR_W'(BUF_BYTES));
        lock_eff = lock_q | lock_in;
        wr_stat  = bus_we && bus_addr == OFS_STAT;
        wr_ctrl  = bus_we && bus_addr == OFS_CTRL;
        wr_addr  = bus_we && bus_addr == OFS_ADDR;
        wr_pref  = bus_we && bus_addr == OFS_PREF    && !lock_eff;
        wr_type  = bus_we && bus_addr == OFS_TYPE    && !lock_eff;
        wr_mlo   = bus_we && bus_addr == OFS_MENU_LO && !lock_eff;
        wr_mhi   = bus_we && bus_addr == OFS_MENU_HI && !lock_eff;
    end

    // Start request and the table entry it selects, taken from the write data
    always_comb begin
        idx_w      = bus_wdata[CT_IDX +: 3];
        go         = wr_ctrl && bus_wdata[CT_GO] && !busy;
        go_atom    = bus_wdata[CT_ATOM];
        go_den     = bus_wdata[CT_DEN];
        go_cnt     = bus_wdata[CT_CNT +: CNT_W];
        go_addr    = addr_q[23:0];
        sel_opcode = menu_q[{idx_w, 3'b000} +: 8];
        sel_type   = type_q[{idx_w, 1'b0} +: 2];
        sel_prefix = bus_wdata[CT_PSEL] ? pref_q[15:8] : pref_q[7:0];
    end

    // Control, address and table registers, lock and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            pref_q  <= '0;
            type_q  <= '0;
            menu_q  <= '0;
            lock_q  <= 1'b0;
            st_done <= 1'b0;
            st_err  <= 1'b0;
        end else begin
            lock_q <= lock_eff;
            if (wr_ctrl && !busy) begin
                ctrl_q         <= bus_wdata[15:0];
                ctrl_q[CT_GO]  <= 1'b0;
            end
            if (wr_addr) addr_q         <= bus_wdata;
            if (wr_pref) pref_q         <= bus_wdata[15:0];
            if (wr_type) type_q         <= bus_wdata[15:0];
            if (wr_mlo)  menu_q[31:0]   <= bus_wdata;
            if (wr_mhi)  menu_q[63:32]  <= bus_wdata;
            if (cyc_end)
                st_done <= 1'b1;
            else if (wr_stat && bus_wdata[ST_DONE])
                st_done <= 1'b0;
            if (wr_ctrl && bus_wdata[CT_GO] && busy)
                st_err <= 1'b1;
            else if (wr_stat && bus_wdata[ST_ERR])
                st_err <= 1'b0;
        end
    end

    // Byte buffer: bus word writes when idle, received bytes during a cycle
    always_ff @(posedge clk) begin
        if (bus_we && buf_hit && !busy) begin
            for (int b = 0; b < 4; b++)
                buf_q[{wsel, b[1:0]}] <= bus_wdata[8*b +: 8];
        end
        if (buf_we)
            buf_q[buf_wr_idx] <= buf_wr_byte;
    end

    assign buf_rd_byte = buf_q[buf_rd_idx];

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (buf_hit) begin
            for (int b = 0; b < 4; b++)
                bus_rdata[8*b +: 8] = buf_q[{wsel, b[1:0]}];
        end else begin
            case (bus_addr)
                OFS_STAT: begin
                    bus_rdata[ST_BUSY] = busy;
                    bus_rdata[ST_DONE] = st_done;
                    bus_rdata[ST_ERR]  = st_err;
                end
                OFS_CTRL:    bus_rdata = {16'h0, ctrl_q};
                OFS_ADDR:    bus_rdata = addr_q;
                OFS_PREF:    bus_rdata = {16'h0, pref_q};
                OFS_TYPE:    bus_rdata = {16'h0, type_q};
                OFS_MENU_LO: bus_rdata = menu_q[31:0];
                OFS_MENU_HI: bus_rdata = menu_q[63:32];
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/opmenu_spi_shift.sv
// One-byte SPI mode 0 shifter. The serial clock half period is HALF_DIV
// system clocks. MISO is sampled on the rising edge and the next MOSI bit is
// presented on the falling edge. Assumes start arrives only when idle.
module opmenu_spi_shift #(
    parameter int HALF_DIV = 2,
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic             act;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;

    // Clock divider, edge generation and bit shifting
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n) begin
            act     <= 1'b0;
            sclk    <= 1'b0;
            sh_q    <= '0;
            bit_q   <= '0;
            div_q   <= '0;
            rx_byte <= '0;
        end else if (start) begin
            act   <= 1'b1;
            sclk  <= 1'b0;
            sh_q  <= tx_byte;
            bit_q <= '0;
            div_q <= '0;
        end else if (act) begin
            if (div_q == DIV_W'(HALF_DIV - 1)) begin
                div_q <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign mosi = sh_q[7];
endmodule

// File: rtl/opmenu_spi_seq.sv
// Transaction sequencer. Latches the selected table entry on start. Walks
// prefix frame, chip-select gap, opcode, address and data bytes, and drives
// chip select. Assumes the shifter reports each byte with a one-cycle done.
module opmenu_spi_seq
    import opmenu_spi_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int GAP_CYC = 8,
    localparam int GAP_W  = $clog2(GAP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_atom,
    input  logic             go_den,
    input  logic [CNT_W-1:0] go_cnt,
    input  logic [23:0]      go_addr,
    input  logic [7:0]       sel_opcode,
    input  logic [1:0]       sel_type,
    input  logic [7:0]       sel_prefix,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic [7:0]       buf_rd_byte,
    output logic             busy,
    output logic             cyc_end,
    output logic             cs_n,
    output logic             kick,
    output logic [7:0]       tx_byte,
    output logic [CNT_W-1:0] buf_rd_idx,
    output logic             buf_we,
    output logic [CNT_W-1:0] buf_wr_idx,
    output logic [7:0]       buf_wr_byte
);
    phase_t           ph;
    logic [7:0]       opc_q, pre_q;
    logic [1:0]       typ_q;
    logic [23:0]      adr_q;
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic             den_q;
    logic [GAP_W-1:0] gap_q;

    // Phase walk, chip select and byte launch
    always_ff @(posedge clk) begin
        kick    <= 1'b0;
        cyc_end <= 1'b0;
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cs_n  <= 1'b1;
            opc_q <= '0;
            pre_q <= '0;
            typ_q <= '0;
            adr_q <= '0;
            cnt_q <= '0;
            den_q <= 1'b0;
            idx_q <= '0;
            gap_q <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (go) begin
                    opc_q <= sel_opcode;
                    typ_q <= sel_type;
                    pre_q <= sel_prefix;
                    adr_q <= go_addr;
                    cnt_q <= go_cnt;
                    den_q <= go_den;
                    idx_q <= '0;
                    cs_n  <= 1'b0;
                    kick  <= 1'b1;
                    ph    <= go_atom ? PH_PRE : PH_CMD;
                end
                PH_PRE: if (byte_done) begin
                    cs_n  <= 1'b1;
                    gap_q <= '0;
                    ph    <= PH_GAP;
                end
                PH_GAP: begin
                    if (gap_q == GAP_W'(GAP_CYC - 1)) begin
                        cs_n <= 1'b0;
                        kick <= 1'b1;
                        ph   <= PH_CMD;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                PH_CMD: if (byte_done) begin
                    idx_q <= '0;
                    if (typ_q[1]) begin
                        ph   <= PH_ADR;
                        kick <= 1'b1;
                    end else if (den_q) begin
                        ph   <= PH_DAT;
                        kick <= 1'b1;
                    end else begin
                        ph      <= PH_IDLE;
                        cs_n    <= 1'b1;
                        cyc_end <= 1'b1;
                    end
                end
                PH_ADR: if (byte_done) begin
                    if (idx_q == CNT_W'(2)) begin
                        idx_q <= '0;
                        if (den_q) begin
                            ph   <= PH_DAT;
                            kick <= 1'b1;
                        end else begin
                            ph      <= PH_IDLE;
                            cs_n    <= 1'b1;
                            cyc_end <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + CNT_W'(1);
                        kick  <= 1'b1;
                    end
                end
                PH_DAT: if (byte_done) begin
                    if (idx_q == cnt_q) begin
                        ph      <= PH_IDLE;
                        cs_n    <= 1'b1;
                        cyc_end <= 1'b1;
                    end else begin
                        idx_q <= idx_q + CNT_W'(1);
                        kick  <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Outgoing byte selection per phase
    always_comb begin
        case (ph)
            PH_PRE:  tx_byte = pre_q;
            PH_CMD:  tx_byte = opc_q;
            PH_ADR:  tx_byte = (idx_q == CNT_W'(0)) ? adr_q[23:16] :
                               (idx_q == CNT_W'(1)) ? adr_q[15:8] : adr_q[7:0];
            PH_DAT:  tx_byte = typ_q[0] ? buf_rd_byte : 8'h00;
            default: tx_byte = 8'h00;
        endcase
    end

    assign busy        = (ph != PH_IDLE);
    assign buf_rd_idx  = idx_q;
    assign buf_we      = (ph == PH_DAT) && byte_done && !typ_q[0];
    assign buf_wr_idx  = idx_q;
    assign buf_wr_byte = rx_byte;
endmodule

// File: rtl/opmenu_spi_ctrl.sv
// Top level of the opcode-menu SPI flash controller. Connects the register
// file, the transaction sequencer and the byte shifter. Assumes BUF_BYTES is
// a power of two between 4 and 64.
module opmenu_spi_ctrl
    import opmenu_spi_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int SCK_HALF  = 2,
    parameter int GAP_SCK   = 2,
    localparam int CNT_W    = $clog2(BUF_BYTES),
    localparam int GAP_CYC  = 2 * SCK_HALF * GAP_SCK
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_in,
    input  logic        bus_we,
    input  logic [6:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic             busy, cyc_end, go, go_atom, go_den;
    logic [CNT_W-1:0] go_cnt, buf_rd_idx, buf_wr_idx;
    logic [23:0]      go_addr;
    logic [7:0]       sel_opcode, sel_prefix, buf_rd_byte, buf_wr_byte;
    logic [1:0]       sel_type;
    logic             buf_we, kick, byte_done;
    logic [7:0]       tx_byte, rx_byte;
    logic             st_done, st_err, lock_q;
    logic [63:0]      menu_q;

    opmenu_spi_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy), .cyc_end(cyc_end),
        .go(go), .go_atom(go_atom), .go_den(go_den), .go_cnt(go_cnt),
        .go_addr(go_addr), .sel_opcode(sel_opcode), .sel_type(sel_type),
        .sel_prefix(sel_prefix), .buf_rd_idx(buf_rd_idx),
        .buf_rd_byte(buf_rd_byte), .buf_we(buf_we), .buf_wr_idx(buf_wr_idx),
        .buf_wr_byte(buf_wr_byte), .st_done(st_done), .st_err(st_err),
        .lock_q(lock_q), .menu_q(menu_q)
    );

    opmenu_spi_seq #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .go_atom(go_atom),
        .go_den(go_den), .go_cnt(go_cnt), .go_addr(go_addr),
        .sel_opcode(sel_opcode), .sel_type(sel_type),
        .sel_prefix(sel_prefix), .byte_done(byte_done), .rx_byte(rx_byte),
        .buf_rd_byte(buf_rd_byte), .busy(busy), .cyc_end(cyc_end),
        .cs_n(spi_cs_n), .kick(kick), .tx_byte(tx_byte),
        .buf_rd_idx(buf_rd_idx), .buf_we(buf_we), .buf_wr_idx(buf_wr_idx),
        .buf_wr_byte(buf_wr_byte)
    );

    opmenu_spi_shift #(.HALF_DIV(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(kick), .tx_byte(tx_byte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(byte_done), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/opmenu_spi_chk.sv
// Assertion checker for the opcode-menu SPI controller, bound to the top.
module opmenu_spi_chk
    import opmenu_spi_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sclk,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        lock_q,
    input logic [63:0] menu,
    input logic        bus_we,
    input logic [6:0]  bus_addr,
    input logic [31:0] bus_wdata
);
    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R2
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> done); // R2
    AST_ERR_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(bus_we && bus_addr == OFS_CTRL && bus_wdata[CT_GO])); // R3
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R11
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> lock_q); // R10
    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && $past(lock_q)) |-> $stable(menu)); // R10
endmodule

bind opmenu_spi_ctrl opmenu_spi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .busy(busy), .done(st_done), .err(st_err), .lock_q(lock_q),
    .menu(menu_q), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/opmenu_spi_ctrl_test.sv
module opmenu_spi_ctrl_test;
    localparam int SCK_HALF = 2;
    localparam int MIN_GAP_NS = 2 * 2 * SCK_HALF * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_in = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    opmenu_spi_ctrl #(.BUF_BYTES(64), .SCK_HALF(SCK_HALF), .GAP_SCK(2)) uut (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Flash model: logs bytes per frame, answers by byte position
    int        nfr = 0;
    int        bc = 0;
    logic [7:0] sh_in = '0;
    logic [7:0] fb [0:1][0:71];
    int        flen [0:1];
    time       t_hi = 0;
    time       gap_ns = 0;

    function automatic logic [7:0] resp(input int p);
        return 8'(p * 29 + 90);
    endfunction

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'(k * 13 + i * 31 + 1);
    endfunction

    assign spi_miso = resp(bc / 8)[7 - (bc % 8)];

    always @(negedge spi_cs_n) begin
        bc = 0;
        if (nfr < 2) flen[nfr] = 0;
        if (nfr > 0) gap_ns = $time - t_hi;
    end

    always @(posedge spi_cs_n) begin
        nfr = nfr + 1;
        t_hi = $time;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sh_in = {sh_in[6:0], spi_mosi};
            bc = bc + 1;
            if (bc % 8 == 0 && nfr < 2 && bc / 8 <= 72) begin
                fb[nfr][bc / 8 - 1] = sh_in;
                flen[nfr] = bc / 8;
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL R2 watchdog: act=running exp=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [7:0]  menu_b [8] = '{8'h02, 8'h03, 8'hD8, 8'h05, 8'hAB, 8'h01, 8'h9F, 8'hC7};
    logic [7:0]  pref_b [2] = '{8'h06, 8'h50};
    logic [15:0] types_b;

    task automatic fill_buf(input int i);
        for (int w = 0; w < 16; w++)
            bus_wr(7'h10 + 7'(4 * w), {pat(4*w+3, i), pat(4*w+2, i), pat(4*w+1, i), pat(4*w, i)});
    endtask

    task automatic run_op(input int i, input bit atom, input bit psel,
                          input bit den, input int cnt, input bit dbl);
        logic [31:0] ctrl, st, a, w;
        logic [1:0]  ty;
        int          f, hdr, n, guard;
        ty = types_b[2*i +: 2];
        a  = 32'hA500_0000 + 32'(i) * 32'h0011_2233 + 32'h000F_0E0D;
        fill_buf(i);
        bus_wr(7'h08, a);
        nfr = 0;
        gap_ns = 0;
        ctrl = (32'(den) << 14) | (32'(cnt) << 8) | (32'(i) << 4) |
               (32'(psel) << 3) | (32'(atom) << 2) | 32'h2;
        bus_wr(7'h04, ctrl);
        if (dbl) begin
            bus_rd(7'h00, st);
            chk("R2 busy after start", int'(st[0]), 1);
            bus_wr(7'h04, ctrl ^ 32'h10);
            bus_rd(7'h00, st);
            chk("R3 err on start while busy", int'(st[3]), 1);
        end
        guard = 0;
        st = '0;
        while (!st[2] && guard < 20000) begin
            bus_rd(7'h00, st);
            guard++;
        end
        chk("R2 done/busy at end", int'(st[3:0] & 4'h5), 4);
        f = atom ? 1 : 0;
        chk("R8 frame count", nfr, atom ? 2 : 1);
        if (atom) begin
            chk("R8 prefix frame length", flen[0], 1);
            chk("R8 prefix byte", int'(fb[0][0]), int'(psel ? pref_b[1] : pref_b[0]));
            chk("R9 cs gap", (gap_ns >= MIN_GAP_NS) ? 1 : 0, 1);
        end
        chk("R4 opcode", int'(fb[f][0]), int'(menu_b[i]));
        hdr = ty[1] ? 4 : 1;
        if (ty[1]) begin
            chk("R4 addr hi", int'(fb[f][1]), int'(a[23:16]));
            chk("R4 addr mid", int'(fb[f][2]), int'(a[15:8]));
            chk("R4 addr lo", int'(fb[f][3]), int'(a[7:0]));
        end
        n = den ? cnt + 1 : 0;
        chk(den ? "R5 frame length" : "R7 frame length", flen[f], hdr + n);
        for (int k = 0; k < n; k++) begin
            if (ty[0]) begin
                chk("R5 write byte", int'(fb[f][hdr + k]), int'(pat(k, i)));
            end else begin
                bus_rd(7'h10 + 7'(4 * (k / 4)), w);
                chk("R6 read byte", int'(w[8*(k%4) +: 8]), int'(resp(hdr + k)));
            end
        end
        bus_wr(7'h00, 32'hC);
        bus_rd(7'h00, st);
        chk("R2 w1c clear", int'(st), 0);
    endtask

    initial begin
        logic [31:0] d;
        types_b = '0;
        for (int i = 0; i < 8; i++) types_b[2*i +: 2] = 2'(i % 4);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        bus_rd(7'h00, d); chk("R1 reset status", int'(d), 0);
        bus_rd(7'h58, d); chk("R1 reset menu", int'(d), 0);
        bus_rd(7'h54, d); chk("R1 reset types", int'(d), 0);

        bus_wr(7'h50, {16'h0, pref_b[1], pref_b[0]});
        bus_wr(7'h54, {16'h0, types_b});
        bus_wr(7'h58, {menu_b[3], menu_b[2], menu_b[1], menu_b[0]});
        bus_wr(7'h5C, {menu_b[7], menu_b[6], menu_b[5], menu_b[4]});
        bus_rd(7'h50, d); chk("R1 prefix readback", int'(d), int'({pref_b[1], pref_b[0]}));
        bus_rd(7'h54, d); chk("R1 types readback", int'(d), int'(types_b));
        bus_rd(7'h5C, d); chk("R1 menu hi readback", int'(d),
                              int'({menu_b[7], menu_b[6], menu_b[5], menu_b[4]}));

        // Sweep every menu entry and type; odd entries atomic, entry 6 no data
        for (int i = 0; i < 8; i++)
            run_op(i, i[0], i[1], i != 6, (i * 9) % 64, 1'b0);

        // No-address read with data disabled, and start while busy
        run_op(0, 1'b0, 1'b0, 1'b0, 5, 1'b0);
        run_op(3, 1'b1, 1'b0, 1'b1, 63, 1'b1);

        // Lock freezes the table
        @(negedge clk); lock_in = 1'b1;
        @(negedge clk); lock_in = 1'b0;
        bus_wr(7'h58, 32'hFFFF_FFFF);
        bus_wr(7'h54, 32'h0000_FFFF);
        bus_wr(7'h50, 32'h0000_1234);
        bus_rd(7'h58, d); chk("R10 menu locked", int'(d),
                              int'({menu_b[3], menu_b[2], menu_b[1], menu_b[0]}));
        bus_rd(7'h54, d); chk("R10 types locked", int'(d), int'(types_b));
        bus_rd(7'h50, d); chk("R10 prefix locked", int'(d), int'({pref_b[1], pref_b[0]}));
        run_op(2, 1'b0, 1'b0, 1'b1, 3, 1'b0);

        summary();
        $finish;
    end
endmodule